// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Address Marking and Break

This block turns bytes into asynchronous serial frames on a single output line. A character enters through a one-deep holding buffer. When the serializer is idle, the character is loaded on the next bit-rate tick and shifted out. Each frame holds a low start bit, then 7 or 8 data bits in the chosen bit order, then an optional address bit for multi-drop links, then an optional parity bit, and ends with a high stop bit. The bit-rate tick is a one-cycle pulse that comes from outside the block. Each bit lasts exactly one tick interval.

Two one-shot controls act on the next frame to start. The address control sets the address bit of that frame. The break control replaces that frame with a break: the line is held low for every bit position except the stop bit. Each control clears itself in the cycle its frame starts. A set request that arrives in that same cycle is kept and applies to the following frame. A busy output shows a frame in progress, and a buffer-empty output shows whether a new write can be taken. A synchronous software-reset input returns the block to idle.

Top module: `uart_tx_frame`

## Requirements
- R1: After reset, tx_line is 1, busy is 0, buf_empty is 1, and addr_pend and brk_pend are 0. While no frame is in progress the line stays at 1.
- R2: A write (wr_en) is accepted only while buf_empty is 1, and buf_empty reads 0 in the following cycle. A write while the buffer is full is dropped: the held character is unchanged and no extra frame is ever sent for it.
- R3: A held character starts its frame on a cycle with bit_tick high while busy is 0. Starting with the start bit (0), the line shows one frame bit per tick interval, in this order: start, data, address bit if enabled, parity if enabled, stop (1).
- R4: With cfg_msb_first 0 the data bits go out from bit 0 upward. With cfg_msb_first 1 they go out from the highest data bit downward.
- R5: With cfg_short_char 1 the frame carries 7 data bits, taken from wr_data[6:0], and wr_data[7] is never sent. With cfg_short_char 0 it carries 8 data bits.
- R6: With cfg_par_en 1 a parity bit follows the data and the address bits. It covers the data bits only. It is the XOR of the data bits when cfg_par_odd is 0, and the inverse of that XOR when cfg_par_odd is 1. With cfg_par_en 0 there is no parity bit.
- R7: With cfg_addr_bit_en 1 an address bit follows the data bits. It is 1 if the address control was set when the frame started and 0 otherwise. With cfg_addr_bit_en 0 there is no address bit.
- R8: If the break control is set when a frame starts, the line is 0 for every bit position of that frame except the last, and 1 for the last (the stop bit). The frame length is the one the configuration gives.
- R9: A pulse on addr_set or brk_set sets the matching control, shown on addr_pend or brk_pend. The control clears in the cycle its frame starts.
- R10: A set pulse in the same cycle as a frame start leaves the control set after that start. The control then applies to the next frame.
- R11: busy goes to 1 at frame start. It stays at 1 until the tick that ends the stop bit, and falls only on a tick or on software reset.
- R12: soft_rst forces, from the next cycle on, tx_line to 1, busy to 0, buf_empty to 1, and both controls to 0. A write in the same cycle as soft_rst is dropped.
- R13: The configuration inputs are sampled at frame start. Changing them while a frame is in progress has no effect on that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| soft_rst | input | 1 | Synchronous software reset, active high |
| bit_tick | input | 1 | One-cycle pulse per bit time |
| wr_en | input | 1 | Write strobe for the holding buffer |
| wr_data | input | DATA_W | Character to send |
| cfg_msb_first | input | 1 | 1: highest data bit first |
| cfg_short_char | input | 1 | 1: 7 data bits, 0: 8 data bits |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 1: odd parity, 0: even parity |
| cfg_addr_bit_en | input | 1 | Address-bit multi-drop format enable |
| addr_set | input | 1 | Pulse: mark next frame as address |
| brk_set | input | 1 | Pulse: send next frame as break |
| tx_line | output | 1 | Serial output, idles high |
| busy | output | 1 | Frame in progress |
| buf_empty | output | 1 | Holding buffer can accept a write |
| addr_pend | output | 1 | Address control currently set |
| brk_pend | output | 1 | Break control currently set |

## Verification
The self-clearing of a one-shot control at frame start can fall in the same cycle as a new set request for that control. The bench provokes this by waiting, after a write, for the first tick cycle in which the buffer is full and the serializer is idle, and pulsing addr_set exactly there. It then judges the outcome in three places: the starting frame's address bit must be 0, addr_pend must still read 1 afterwards, and the next frame must carry address bit 1 and clear the control. A write that meets a full buffer while a frame is in progress is a second collision. It is judged by checking that exactly two frames follow.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;

    // start, address, parity and stop positions added to the data bits
    localparam int FRAME_EXTRA = 4;

    typedef struct packed {
        logic msb_first;
        logic short_char;
        logic par_en;
        logic par_odd;
        logic addr_bit_en;
    } tx_cfg_t;

endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              addr_set,
    input  logic              brk_set,
    input  logic              take,
    output logic              full,
    output logic [DATA_W-1:0] data,
    output logic              addr_ctl,
    output logic              brk_ctl
);

    typedef struct packed {
        logic              full;
        logic [DATA_W-1:0] data;
        logic              addr;
        logic              brk;
    } hold_t;

    hold_t h_d, h_q;

    always_comb begin
        h_d = h_q;
        if (take) begin
            h_d.full = 1'b0;
            h_d.addr = 1'b0;
            h_d.brk  = 1'b0;
        end
        if (wr_en && !h_q.full) begin
            h_d.full = 1'b1;
            h_d.data = wr_data;
        end
        // a request in the start cycle survives the self-clear
        if (addr_set) h_d.addr = 1'b1;
        if (brk_set)  h_d.brk  = 1'b1;
        if (soft_rst) h_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) h_q <= '0;
        else        h_q <= h_d;
    end

    assign full     = h_q.full;
    assign data     = h_q.data;
    assign addr_ctl = h_q.addr;
    assign brk_ctl  = h_q.brk;

    AST_FULL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        full && !take && !soft_rst |=> full && $stable(data)); // R2
    AST_ADDR_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        take && !addr_set |=> !addr_ctl); // R9
    AST_BRK_ONESHOT: assert property (@(posedge clk) disable iff (!rst_n)
        take && !brk_set |=> !brk_ctl); // R9
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        take && addr_set && !soft_rst |=> addr_ctl); // R10

endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
    import uart_tx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int FRAME_W = DATA_W + FRAME_EXTRA,
    parameter int LEN_W   = $clog2(FRAME_W + 1)
) (
    input  logic [DATA_W-1:0]  data,
    input  tx_cfg_t            cfg,
    input  logic               addr_bit,
    input  logic               brk,
    output logic [FRAME_W-1:0] vec,
    output logic [LEN_W-1:0]   len
);

    int   nd;
    int   pos;
    logic par;

    always_comb begin
        nd  = cfg.short_char ? DATA_W - 1 : DATA_W;
        par = cfg.par_odd;
        vec = '1;
        vec[0] = 1'b0;
        for (int i = 0; i < DATA_W; i++) begin
            if (i < nd) begin
                vec[1 + i] = cfg.msb_first ? data[nd - 1 - i] : data[i];
                par        = par ^ data[i];
            end
        end
        pos = nd + 1;
        if (cfg.addr_bit_en) begin
            vec[pos] = addr_bit;
            pos      = pos + 1;
        end
        if (cfg.par_en) begin
            vec[pos] = par;
            pos      = pos + 1;
        end
        // position pos is the stop bit, already high
        len = LEN_W'(pos + 1);
        if (brk) begin
            for (int k = 0; k < FRAME_W; k++) vec[k] = (k >= pos);
        end
    end

endmodule

// File: rtl/uart_tx_serializer.sv
module uart_tx_serializer #(
    parameter int FRAME_W = 12,
    parameter int LEN_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               soft_rst,
    input  logic               bit_tick,
    input  logic               load,
    input  logic [FRAME_W-1:0] vec,
    input  logic [LEN_W-1:0]   len,
    output logic               busy,
    output logic               line
);

    typedef struct packed {
        logic               busy;
        logic [FRAME_W-1:0] sh;
        logic [LEN_W-1:0]   left;
    } ser_t;

    ser_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load) begin
            s_d.busy = 1'b1;
            s_d.sh   = vec;
            s_d.left = len;
        end else if (s_q.busy && bit_tick) begin
            s_d.sh   = {1'b1, s_q.sh[FRAME_W-1:1]};
            s_d.left = s_q.left - LEN_W'(1);
            if (s_q.left == LEN_W'(1)) s_d.busy = 1'b0;
        end
        if (soft_rst) s_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy = s_q.busy;
    assign line = s_q.busy ? s_q.sh[0] : 1'b1;

    AST_BUSY_FALLS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) && !$past(soft_rst) |-> $past(bit_tick)); // R11
    AST_LINE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        busy && !bit_tick && !soft_rst |=> busy && $stable(line)); // R3

endmodule

// File: rtl/uart_tx_frame.sv
module uart_tx_frame
    import uart_tx_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              bit_tick,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              cfg_msb_first,
    input  logic              cfg_short_char,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic              cfg_addr_bit_en,
    input  logic              addr_set,
    input  logic              brk_set,
    output logic              tx_line,
    output logic              busy,
    output logic              buf_empty,
    output logic              addr_pend,
    output logic              brk_pend
);

    localparam int FRAME_W = DATA_W + FRAME_EXTRA;
    localparam int LEN_W   = $clog2(FRAME_W + 1);

    logic               full;
    logic [DATA_W-1:0]  held;
    logic               addr_ctl;
    logic               brk_ctl;
    logic               take;
    tx_cfg_t            cfg;
    logic [FRAME_W-1:0] vec;
    logic [LEN_W-1:0]   len;

    assign cfg = '{msb_first:   cfg_msb_first,
                   short_char:  cfg_short_char,
                   par_en:      cfg_par_en,
                   par_odd:     cfg_par_odd,
                   addr_bit_en: cfg_addr_bit_en};

    // a frame starts on a tick so the start bit lasts a full bit time
    assign take = full && !busy && bit_tick && !soft_rst;

    uart_tx_hold #(.DATA_W(DATA_W)) u_hold (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .wr_en    (wr_en),
        .wr_data  (wr_data),
        .addr_set (addr_set),
        .brk_set  (brk_set),
        .take     (take),
        .full     (full),
        .data     (held),
        .addr_ctl (addr_ctl),
        .brk_ctl  (brk_ctl)
    );

    uart_tx_framer #(.DATA_W(DATA_W), .FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_framer (
        .data     (held),
        .cfg      (cfg),
        .addr_bit (addr_ctl),
        .brk      (brk_ctl),
        .vec      (vec),
        .len      (len)
    );

    uart_tx_serializer #(.FRAME_W(FRAME_W), .LEN_W(LEN_W)) u_ser (
        .clk      (clk),
        .rst_n    (rst_n),
        .soft_rst (soft_rst),
        .bit_tick (bit_tick),
        .load     (take),
        .vec      (vec),
        .len      (len),
        .busy     (busy),
        .line     (tx_line)
    );

    assign buf_empty = !full;
    assign addr_pend = addr_ctl;
    assign brk_pend  = brk_ctl;

    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> busy && !tx_line); // R3
    AST_BRK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        take && brk_ctl |=> !tx_line); // R8
    AST_SRST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> tx_line && !busy && buf_empty && !addr_pend && !brk_pend); // R12
    AST_WRITE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && buf_empty && !soft_rst |=> !buf_empty); // R2
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy && !take |=> tx_line); // R1

endmodule

// File: tb/uart_tx_frame_tb.sv
module uart_tx_frame_tb;

    localparam int CLK_P    = 10;
    localparam int TICK_DIV = 4;
    localparam int FW       = 12;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       soft_rst = 1'b0;
    logic       bit_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       c_msb = 1'b0, c_short = 1'b0, c_pen = 1'b0, c_podd = 1'b0, c_aen = 1'b0;
    logic       addr_set = 1'b0, brk_set = 1'b0;
    logic       tx_line, busy, buf_empty, addr_pend, brk_pend;

    int n_run = 0;
    int n_fail = 0;
    int tdiv = 0;
    bit done = 1'b0;

    uart_tx_frame u_dut (
        .clk(clk), .rst_n(rst_n), .soft_rst(soft_rst), .bit_tick(bit_tick),
        .wr_en(wr_en), .wr_data(wr_data),
        .cfg_msb_first(c_msb), .cfg_short_char(c_short), .cfg_par_en(c_pen),
        .cfg_par_odd(c_podd), .cfg_addr_bit_en(c_aen),
        .addr_set(addr_set), .brk_set(brk_set),
        .tx_line(tx_line), .busy(busy), .buf_empty(buf_empty),
        .addr_pend(addr_pend), .brk_pend(brk_pend)
    );

    always #(CLK_P / 2) clk = ~clk;

    always @(posedge clk) begin
        tdiv     <= (tdiv == TICK_DIV - 1) ? 0 : tdiv + 1;
        bit_tick <= (tdiv == TICK_DIV - 1);
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // expected frame, written from the requirements
    function automatic void model(input logic [7:0] d, input bit sc, msb, pe, po, ae, a, b,
                                  output logic [FW-1:0] v, output int n);
        bit q[$];
        int nd;
        bit p;
        nd = sc ? 7 : 8;
        p  = po;
        q.push_back(1'b0);
        if (msb) for (int i = nd - 1; i >= 0; i--) q.push_back(d[i]);
        else     for (int i = 0; i < nd; i++)       q.push_back(d[i]);
        for (int i = 0; i < nd; i++) p ^= d[i];
        if (ae) q.push_back(a);
        if (pe) q.push_back(p);
        q.push_back(1'b1);
        n = q.size();
        v = '1;
        for (int k = 0; k < n; k++) v[k] = b ? (k == n - 1) : q[k];
    endfunction

    task automatic write_byte(input logic [7:0] d);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic pulse_addr();
        @(negedge clk); addr_set = 1'b1;
        @(negedge clk); addr_set = 1'b0;
    endtask

    task automatic pulse_brk();
        @(negedge clk); brk_set = 1'b1;
        @(negedge clk); brk_set = 1'b0;
    endtask

    task automatic wait_busy(input string req);
        int t;
        t = 0;
        while (!busy && t < 100) begin
            @(negedge clk);
            t++;
        end
        chk(busy, req, "frame start", busy, 1);
    endtask

    task automatic wait_idle();
        int t;
        t = 0;
        while ((busy || !buf_empty) && t < 400) begin
            @(negedge clk);
            t++;
        end
        repeat (2) @(negedge clk);
    endtask

    // called at the first negedge after frame start
    task automatic recv_check(input logic [FW-1:0] v, input int n, input string req);
        logic [FW-1:0] cap;
        bit            busy_ok;
        cap     = '1;
        busy_ok = 1'b1;
        cap[0]  = tx_line;
        for (int k = 1; k < n; k++) begin
            while (!bit_tick) @(negedge clk);
            @(negedge clk);
            cap[k] = tx_line;
            if (!busy) busy_ok = 1'b0;
        end
        while (!bit_tick) @(negedge clk);
        @(negedge clk);
        chk(cap === v, req, "frame bits", int'(cap), int'(v));
        chk(busy_ok && !busy, "R11", "busy span", int'(busy), 0);
    endtask

    initial begin : main
        logic [FW-1:0] v;
        int            n;
        logic [FW-1:0] v2;
        int            n2;
        logic [7:0]    d;
        bit            a, b;
        string         tag;

        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_line && !busy && buf_empty && !addr_pend && !brk_pend, "R1", "reset state",
            {tx_line, busy, buf_empty, addr_pend, brk_pend}, 5'b10100);

        // R4 R5: 7-bit, MSB first, bit 7 must not appear
        c_short = 1; c_msb = 1;
        model(8'hEB, 1, 1, 0, 0, 0, 0, 0, v, n);
        write_byte(8'hEB);
        wait_busy("R5");
        recv_check(v, n, "R5 short MSB-first");
        wait_idle();

        // R4: 8-bit LSB first
        c_short = 0; c_msb = 0;
        model(8'h1D, 0, 0, 0, 0, 0, 0, 0, v, n);
        write_byte(8'h1D);
        wait_busy("R4");
        recv_check(v, n, "R4 LSB-first");
        wait_idle();

        // R6: odd parity with address bit present
        c_pen = 1; c_podd = 1; c_aen = 1;
        model(8'hA7, 0, 0, 1, 1, 1, 0, 0, v, n);
        write_byte(8'hA7);
        wait_busy("R6");
        recv_check(v, n, "R6 odd parity");
        wait_idle();

        // R7 R9: address frame, control clears at start
        pulse_addr();
        chk(addr_pend, "R9", "addr_pend after set", addr_pend, 1);
        c_podd = 0;
        model(8'h3C, 0, 0, 1, 0, 1, 1, 0, v, n);
        write_byte(8'h3C);
        wait_busy("R7");
        chk(!addr_pend, "R9", "addr_pend cleared at start", addr_pend, 0);
        recv_check(v, n, "R7 address bit");
        wait_idle();

        // R8: break over a full-length frame
        pulse_brk();
        chk(brk_pend, "R9", "brk_pend after set", brk_pend, 1);
        model(8'h00, 0, 0, 1, 0, 1, 0, 1, v, n);
        write_byte(8'h00);
        wait_busy("R8");
        chk(!brk_pend, "R9", "brk_pend cleared at start", brk_pend, 0);
        recv_check(v, n, "R8 break");
        wait_idle();

        // R10: set pulse lands in the start cycle
        model(8'h81, 0, 0, 1, 0, 1, 0, 0, v, n);
        model(8'h42, 0, 0, 1, 0, 1, 1, 0, v2, n2);
        write_byte(8'h81);
        while (!(bit_tick && !busy && !buf_empty)) @(negedge clk);
        addr_set = 1'b1;
        @(negedge clk);
        addr_set = 1'b0;
        chk(busy && addr_pend, "R10", "set survives start", {busy, addr_pend}, 2'b11);
        recv_check(v, n, "R10 first frame address 0");
        write_byte(8'h42);
        wait_busy("R10");
        chk(!addr_pend, "R10", "cleared by second start", addr_pend, 0);
        recv_check(v2, n2, "R10 second frame address 1");
        wait_idle();

        // R2: second write buffered, third dropped
        c_pen = 0; c_aen = 0;
        model(8'h55, 0, 0, 0, 0, 0, 0, 0, v, n);
        model(8'hC3, 0, 0, 0, 0, 0, 0, 0, v2, n2);
        write_byte(8'h55);
        wait_busy("R2");
        fork
            begin
                recv_check(v, n, "R2 frame A");
                wait_busy("R2");
                recv_check(v2, n2, "R2 frame B");
            end
            begin
                write_byte(8'hC3);
                chk(!buf_empty, "R2", "buffer full after write", buf_empty, 0);
                write_byte(8'hFF);
            end
        join
        repeat (3 * TICK_DIV) @(negedge clk);
        chk(!busy && buf_empty && tx_line, "R2", "no frame for dropped write",
            {busy, buf_empty, tx_line}, 3'b011);

        // R13: configuration changed during a frame
        model(8'h96, 0, 0, 1, 1, 0, 0, 0, v, n);
        c_pen = 1; c_podd = 1;
        write_byte(8'h96);
        wait_busy("R13");
        c_msb = 1; c_short = 1; c_pen = 0; c_aen = 1;
        recv_check(v, n, "R13 config sampled at start");
        c_msb = 0; c_short = 0; c_aen = 0; c_podd = 0;
        wait_idle();

        // R12: software reset mid-frame with full buffer and pending control
        write_byte(8'hF0);
        wait_busy("R12");
        write_byte(8'h0F);
        pulse_addr();
        @(negedge clk);
        soft_rst = 1'b1; wr_en = 1'b1; wr_data = 8'h77;
        @(negedge clk);
        soft_rst = 1'b0; wr_en = 1'b0;
        chk(tx_line && !busy && buf_empty && !addr_pend && !brk_pend, "R12", "after soft reset",
            {tx_line, busy, buf_empty, addr_pend, brk_pend}, 5'b10100);
        repeat (4 * TICK_DIV) @(negedge clk);
        chk(tx_line && !busy, "R12", "stays idle", {tx_line, busy}, 2'b10);
        chk(tx_line, "R1", "idle line high", tx_line, 1);

        // constrained random frames
        for (int it = 0; it < 40; it++) begin
            wait_idle();
            c_msb   = 1'($urandom_range(0, 1));
            c_short = 1'($urandom_range(0, 1));
            c_pen   = 1'($urandom_range(0, 1));
            c_podd  = 1'($urandom_range(0, 1));
            c_aen   = 1'($urandom_range(0, 1));
            a = 1'($urandom_range(0, 1));
            b = ($urandom_range(0, 5) == 0);
            d = b ? 8'h00 : 8'($urandom);
            if (a) pulse_addr();
            if (b) pulse_brk();
            model(d, c_short, c_msb, c_pen, c_podd, c_aen, a, b, v, n);
            write_byte(d);
            wait_busy("R3");
            chk(!addr_pend && !brk_pend, "R9", "controls cleared", {addr_pend, brk_pend}, 0);
            tag = b ? "R8 random" : (c_aen ? "R7 random" : (c_pen ? "R6 random" : "R3 random"));
            recv_check(v, n, tag);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule